// File: doc/BRIEF.md
# Full-Duplex Serial Transceiver on a Triple-Rate Tick

This block is an asynchronous serial transceiver with independent receive and transmit paths that run at the same time. Both paths advance only on a single enable pulse, `tick`, which the surrounding logic supplies at three times the line bit rate. No other timebase exists inside the block. Each frame has one low start bit, then `DATA_W` data bits with the least significant bit first, then one high stop bit. The line is high when idle.

The receive path first passes the line through a synchronizer chain. It then treats the first tick that sees a low level as the start of a frame. Because the tick runs at three times the bit rate, the true falling edge lies at most one third of a bit before that detection tick. The receiver takes data samples at fixed tick offsets from the detection tick, and each sample lands in the middle third of its bit. When the stop bit has been sampled, the received word is presented for one clock, together with a flag that reports a low stop bit.

The transmit path accepts a word through a valid/ready handshake. It starts the frame on the tick that follows acceptance and holds every bit on the line for exactly three ticks, whatever the receive path is doing.

Top module: `uart3x`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: The receiver declares a start on the first tick at which the synchronized line (`SYNC_STAGES` flops, default 2) reads 0. It pulses `rx_valid` on the tick 28 ticks after that detection tick. With a tick every 5 clocks and a bit period of 15 clocks, `rx_valid` is therefore seen 143 to 147 clocks after the start bit is applied.
- R3: Data bit 0 is sampled on the 4th tick after detection, and each later bit is sampled 3 ticks after the one before it. Bits fill `rx_data` from bit 0 upward. The received word is unchanged when the line shows the inverted level during the first and last fifth of every data bit.
- R4: The stop level is sampled 3 ticks after the last data bit. `rx_valid` is high for exactly one clock, and `rx_ferr` is 1 on that clock only if the sampled stop level was 0.
- R5: After a stop bit that reads 0, the receiver does not start a new frame until it has seen the line at 1. A line held low for many frames produces a single `rx_valid` with `rx_ferr` = 1 and `rx_data` = 0.
- R6: `tx_ready` is 1 only while the transmitter is idle. A word is taken when `tx_valid` and `tx_ready` are both 1 on a clock edge, and `tx_ready` is 0 on the next cycle.
- R7: The transmit frame begins on the first tick after acceptance. It sends, in order, a start bit of 0, `tx_data` starting at bit 0, and a stop bit of 1. `txd` is 1 whenever `tx_ready` is 1.
- R8: `txd` changes only on tick cycles, and each frame bit lasts exactly 3 ticks. `tx_ready` returns to 1 on the tick 30 ticks after the start bit began.
- R9: Transmit timing and content are the same whether or not a reception is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock enable pulse at three times the bit rate |
| rxd | input | 1 | Serial receive line, asynchronous |
| rx_data | output | DATA_W | Last received word |
| rx_valid | output | 1 | One-clock pulse when a word has been received |
| rx_ferr | output | 1 | Stop bit read low; valid together with rx_valid |
| tx_data | input | DATA_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter idle and able to take a word |
| txd | output | 1 | Serial transmit line |

## Verification
The bench produces `tick` every 5 clocks, so one bit lasts 15 clocks. It counts clocks from the moment a stimulus is applied. A received word must appear 143 to 147 clocks after the start bit is driven. That window comes from 2 synchronizer flops, up to one tick period of detection slack, and 28 ticks to the stop sample. The transmit start bit must appear 1 to 5 clocks after acceptance. Every frame bit is then checked on both its first and its 15th clock, and `tx_ready` is checked low at 149 clocks and high at 150 clocks after the start bit. All outputs are sampled on the falling clock edge, so each check reads a value that settled after the rising edge it depends on.

// File: rtl/uart3x_pkg.sv
package uart3x_pkg;

   localparam int unsigned TICKS_PER_BIT      = 3;
   localparam int unsigned FIRST_SAMPLE_TICKS = 4;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_DATA,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_ARM,
      TX_SEND
   } tx_state_e;

endpackage

// File: rtl/uart3x_sync.sv
module uart3x_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uart3x_rx.sv
module uart3x_rx
   import uart3x_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_ferr
);
   localparam int unsigned CNT_W = 3;
   localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bit_idx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         rx_ferr  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rx_s) begin
                     state   <= RX_DATA;
                     cnt     <= CNT_W'(FIRST_SAMPLE_TICKS - 1);
                     bit_idx <= '0;
                  end
               end
               RX_DATA: begin
                  if (cnt == '0) begin
                     shreg <= {rx_s, shreg[DATA_W-1:1]};
                     cnt   <= CNT_W'(TICKS_PER_BIT - 1);
                     if (bit_idx == BIT_W'(DATA_W - 1)) state <= RX_STOP;
                     else bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == '0) begin
                     rx_valid <= 1'b1;
                     rx_data  <= shreg;
                     rx_ferr  <= ~rx_s;
                     state    <= rx_s ? RX_IDLE : RX_HOLD;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               RX_HOLD: begin
                  if (rx_s) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R2
   rx_valid_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(tick));

   // R4
   rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R5
   rx_hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_HOLD && tick && !rx_s) |=> state == RX_HOLD);
endmodule

// File: rtl/uart3x_tx.sv
module uart3x_tx
   import uart3x_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd
);
   localparam int unsigned FRAME_W = DATA_W + 2;
   localparam int unsigned CNT_W   = 2;
   localparam int unsigned NB_W    = $clog2(FRAME_W);

   tx_state_e          state;
   logic [FRAME_W-1:0] sr;
   logic [NB_W-1:0]    nbits;
   logic [CNT_W-1:0]   cnt;

   assign tx_ready = (state == TX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         sr    <= '1;
         nbits <= '0;
         cnt   <= '0;
         txd   <= 1'b1;
      end else begin
         unique case (state)
            TX_IDLE: begin
               if (tx_valid) begin
                  sr    <= {1'b1, tx_data, 1'b0};
                  state <= TX_ARM;
               end
            end
            TX_ARM: begin
               if (tick) begin
                  txd   <= sr[0];
                  sr    <= {1'b1, sr[FRAME_W-1:1]};
                  nbits <= NB_W'(FRAME_W - 1);
                  cnt   <= CNT_W'(TICKS_PER_BIT - 1);
                  state <= TX_SEND;
               end
            end
            TX_SEND: begin
               if (tick) begin
                  if (cnt == '0) begin
                     if (nbits == '0) begin
                        state <= TX_IDLE;
                     end else begin
                        txd   <= sr[0];
                        sr    <= {1'b1, sr[FRAME_W-1:1]};
                        nbits <= nbits - 1'b1;
                        cnt   <= CNT_W'(TICKS_PER_BIT - 1);
                     end
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   // R7
   tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> txd);

   // R8
   tx_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(tick));

   // R6
   tx_accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/uart3x.sv
module uart3x
   import uart3x_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_ferr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart3x: DATA_W must lie between 5 and 9");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart3x: SYNC_STAGES must be at least 2");
   end

   logic rx_s;

   uart3x_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rx_s)
   );

   uart3x_rx #(.DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rx_s     (rx_s),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .rx_ferr  (rx_ferr)
   );

   uart3x_tx #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .txd      (txd)
   );
endmodule

// File: tb/uart3x_tb.sv
`timescale 1ns/1ps
module uart3x_tb;
   localparam int TICK_DIV = 5;
   localparam int BIT_CLK  = 3 * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_ferr;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       txd;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;

   uart3x u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
   );

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) tick <= ((cyc % TICK_DIV) == TICK_DIV - 1);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [9:0] tx_frame_bits(input logic [7:0] d);
      return {1'b1, d, 1'b0};
   endfunction

   task automatic rx_frame(input logic [7:0] d, input bit stop_v, input bit noisy, input string req);
      int n, got_cyc;
      logic [7:0] got_d;
      bit got_f, seen;
      seen = 0; got_cyc = 0; got_d = '0; got_f = 0;
      @(negedge clk);
      rxd = 1'b0;
      n = cyc;
      fork
         begin
            repeat (BIT_CLK) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               if (noisy) begin
                  rxd = ~d[i]; repeat (3) @(negedge clk);
                  rxd = d[i];  repeat (9) @(negedge clk);
                  rxd = ~d[i]; repeat (3) @(negedge clk);
               end else begin
                  rxd = d[i];  repeat (BIT_CLK) @(negedge clk);
               end
            end
            rxd = stop_v;
            repeat (BIT_CLK) @(negedge clk);
            rxd = 1'b1;
         end
         begin
            for (int k = 0; k < 200 && !seen; k++) begin
               @(negedge clk);
               if (rx_valid) begin
                  seen = 1; got_cyc = cyc - n; got_d = rx_data; got_f = rx_ferr;
               end
            end
         end
      join
      chk(seen, "R2 rx_valid present", int'(seen), 1);
      chk(got_d == d, {req, " rx_data"}, got_d, d);
      chk(got_f == !stop_v, "R4 rx_ferr", got_f, !stop_v);
      chk(got_cyc >= 143 && got_cyc <= 147, "R2 rx latency 143..147", got_cyc, 145);
   endtask

   task automatic tx_frame(input logic [7:0] d);
      int n, s, k;
      logic [9:0] fr;
      fr = tx_frame_bits(d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data  = d;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      n = cyc;
      chk(!tx_ready, "R6 ready drops after accept", tx_ready, 0);
      k = 0;
      while (txd && k < 20) begin @(negedge clk); k++; end
      s = cyc;
      chk(s - n >= 1 && s - n <= 5, "R7 start on next tick", s - n, 3);
      for (int b = 0; b < 10; b++) begin
         chk(txd == fr[b], "R7 frame bit first clock", txd, fr[b]);
         repeat (BIT_CLK - 1) @(negedge clk);
         chk(txd == fr[b], "R8 frame bit last clock", txd, fr[b]);
         if (b < 9) @(negedge clk);
      end
      chk(!tx_ready, "R8 ready low before 30 ticks", tx_ready, 0);
      @(negedge clk);
      chk(tx_ready, "R8 ready back after 30 ticks", tx_ready, 1);
      chk(txd, "R7 idle line high", txd, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      int cnt_v;
      logic [7:0] bd;
      bit bf;
      seed = $urandom(32'd2024);

      repeat (4) @(negedge clk);
      chk(txd, "R1 txd in reset", txd, 1);
      chk(tx_ready, "R1 tx_ready in reset", tx_ready, 1);
      chk(!rx_valid, "R1 rx_valid in reset", rx_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd && tx_ready && !rx_valid, "R1 state after reset", {txd, tx_ready, rx_valid}, 3'b110);

      // receive, directed
      rx_frame(8'h00, 1'b1, 1'b0, "R3 zeros");
      repeat (7) @(negedge clk);
      rx_frame(8'hFF, 1'b1, 1'b0, "R3 ones");
      repeat (3) @(negedge clk);
      rx_frame(8'hA5, 1'b1, 1'b0, "R3 alternating");
      rx_frame(8'h3C, 1'b1, 1'b1, "R3 edge noise");
      repeat (11) @(negedge clk);
      rx_frame(8'h5A, 1'b0, 1'b0, "R4 low stop");
      repeat (20) @(negedge clk);

      // R5: long low line
      @(negedge clk);
      rxd = 1'b0;
      cnt_v = 0; bd = '1; bf = 0;
      repeat (400) begin
         @(negedge clk);
         if (rx_valid) begin cnt_v++; bd = rx_data; bf = rx_ferr; end
      end
      chk(cnt_v == 1, "R5 one word for held-low line", cnt_v, 1);
      chk(bf, "R5 framing flag", bf, 1);
      chk(bd == 8'h00, "R5 data zero", bd, 0);
      rxd = 1'b1;
      repeat (20) @(negedge clk);
      rx_frame(8'hC3, 1'b1, 1'b0, "R5 recovery");

      // transmit, directed
      tx_frame(8'h00);
      tx_frame(8'hFF);
      repeat (2) @(negedge clk);
      tx_frame(8'h81);

      // R9: full duplex, random data and phase
      for (int it = 0; it < 14; it++) begin
         logic [7:0] td, rd;
         bit nz;
         td = 8'($urandom());
         rd = 8'($urandom());
         nz = 1'($urandom());
         fork
            begin
               repeat ($urandom_range(0, 9)) @(negedge clk);
               tx_frame(td);
            end
            begin
               repeat ($urandom_range(0, BIT_CLK - 1)) @(negedge clk);
               rx_frame(rd, 1'b1, nz, "R9 duplex rx");
            end
         join
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule